// File: doc/BRIEF.md
# I2C Slave Transmitter with Ten-Bit Addressing

This block lets a bus master read bytes from a local CPU over I2C, using a ten-bit slave address. It watches the SCL and SDA lines through synchronisers, detects START, repeated START and STOP, and pulls either line low through open-drain enables. The slave recognises its ten-bit address only in one sequence. The master first writes the two address bytes. It then issues a repeated START and sends the first address byte again, this time with the read bit set. After that the slave shifts out bytes that the CPU has placed in a one-byte data holding register.

The CPU side is a write strobe with a data byte, a flush strobe that discards a pending byte, a status-read strobe, and three sticky flags. The flags are: transmit register empty, master refused the byte, and bus STOP or repeated START seen. Each flag feeds a single interrupt line. A new byte is loaded into the shifter when its first clock period begins. If no byte is waiting at that point, the slave holds SCL low until the CPU writes one. The first byte of a read must therefore be written before the read address, or the bus stays stretched until it is.

Top module: `i2c10_slave_tx`

## Requirements
- R1: With `tx_en`=1, the slave pulls SDA low in the acknowledge clock of a first byte {11110, own_addr[9:8], 0}. It also pulls SDA low in the acknowledge clock of the second byte that follows, when that byte equals own_addr[7:0]. A second byte that differs, or a first byte whose bits 2:1 differ from own_addr[9:8], is not acknowledged.
- R2: A first byte {11110, own_addr[9:8], 1} is acknowledged only if a matching write-direction two-byte address was acknowledged since the last STOP. Otherwise SDA stays released in its acknowledge clock.
- R3: Data bytes appear on SDA most significant bit first, and are equal to the bytes the CPU wrote. The slave only starts pulling SDA low while SCL is low.
- R4: `tde_flag` goes high during the first (most significant) bit clock of each transmitted byte. A CPU write clears it, and the write wins over a same-cycle set.
- R5: If no byte is waiting when a data byte is due to start, the slave holds SCL low. It releases SCL on the cycle after the CPU write.
- R6: A NACK from the master (SDA high in the acknowledge clock) sets `nack_flag`. SDA then stays released until the next START.
- R7: A `flush` pulse discards a waiting byte, so the next byte start stretches SCL.
- R8: `stop_flag` is set by a STOP, or by a repeated START, that ends a transfer in which the slave acknowledged a byte. A `rd_status` pulse clears both `stop_flag` and `nack_flag`. With no acknowledge, `stop_flag` stays low.
- R9: With `gc_en`=1 the byte 0x00 after START is acknowledged. With `gc_en`=0 it is not.
- R10: With `tx_en`=0 no address byte is acknowledged.
- R11: `irq` is high whenever any of the three flags is high.
- R12: After reset both line enables are low and all flags and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | ADDR_W | Ten-bit own slave address |
| gc_en | input | 1 | Acknowledge general call 0x00 |
| tx_en | input | 1 | Enable address acknowledge |
| wr_en | input | 1 | CPU write strobe for the data register |
| wr_data | input | 8 | Byte written by the CPU |
| flush | input | 1 | Discard the waiting byte |
| rd_status | input | 1 | Status read strobe, clears stop and NACK flags |
| tde_flag | output | 1 | Transmit register empty |
| nack_flag | output | 1 | Master refused a byte |
| stop_flag | output | 1 | STOP or repeated START after an acknowledged transfer |
| irq | output | 1 | OR of the three flags |

## Verification
The hardest state to reach from the ports is the mid-transfer clock stretch. It needs the master to acknowledge a byte while the CPU has not yet supplied the next one, with the bus model waiting on the shared SCL wire instead of its own drive. The bench's master model always releases SCL and then waits for the wired level to rise. Random transactions sometimes delay the CPU write until after the master's acknowledge. A directed case flushes a preloaded byte so that the stretch falls on the very first data byte after the read address.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_LOAD,
    ST_TX,
    ST_MACK,
    ST_MWAIT,
    ST_SKIP
  } eng_st_t;

  typedef enum logic [2:0] {
    DEC_NONE,
    DEC_W1,
    DEC_W2,
    DEC_RD,
    DEC_GC
  } dec_t;
endpackage

// File: rtl/i2c10_line_sync.sv
module i2c10_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_q = scl_pipe[SYNC_STAGES-1];
  assign sda_q = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign bus_start = scl_q & scl_d & sda_d & ~sda_q;
  assign bus_stop  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c10_txbuf.sv
module i2c10_txbuf
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flush,
  input  logic              take,
  input  logic              first_bit,
  output logic [BYTE_W-1:0] buf_data,
  output logic              buf_full,
  output logic              tde_flag
);
  logic [BYTE_W-1:0] data_n;
  logic full_n, tde_n;

  always_comb begin
    data_n = buf_data;
    full_n = buf_full;
    tde_n  = tde_flag;
    if (wr_en) begin
      data_n = wr_data;
      full_n = 1'b1;
    end else if (flush || take) begin
      full_n = 1'b0;
    end
    if (wr_en) begin
      tde_n = 1'b0;
    end else if (first_bit) begin
      tde_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data <= '0;
      buf_full <= 1'b0;
      tde_flag <= 1'b0;
    end else begin
      buf_data <= data_n;
      buf_full <= full_n;
      tde_flag <= tde_n;
    end
  end
endmodule

// File: rtl/i2c10_status.sv
module i2c10_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stop,
  input  logic set_nack,
  input  logic rd_status,
  input  logic tde_flag,
  output logic stop_flag,
  output logic nack_flag,
  output logic irq
);
  logic stop_n, nack_n;

  always_comb begin
    stop_n = stop_flag;
    nack_n = nack_flag;
    if (rd_status) begin
      stop_n = 1'b0;
      nack_n = 1'b0;
    end
    if (set_stop) stop_n = 1'b1;
    if (set_nack) nack_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_flag <= 1'b0;
      nack_flag <= 1'b0;
    end else begin
      stop_flag <= stop_n;
      nack_flag <= nack_n;
    end
  end

  assign irq = stop_flag | nack_flag | tde_flag;
endmodule

// File: rtl/i2c10_engine.sv
module i2c10_engine
  import i2c10_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              tx_en,
  input  logic              buf_full,
  input  logic [BYTE_W-1:0] buf_data,
  output logic              take,
  output logic              first_bit,
  output logic              set_stop,
  output logic              set_nack,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_st_t st, st_n;
  dec_t dec, dec_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, rxb;
  logic second, second_n, matched, matched_n, engaged, engaged_n;

  assign rxb = {sh[BYTE_W-2:0], sda_q};

  always_comb begin
    st_n = st;
    dec_n = dec;
    cnt_n = cnt;
    sh_n = sh;
    second_n = second;
    matched_n = matched;
    engaged_n = engaged;
    take = 1'b0;
    first_bit = 1'b0;
    set_stop = 1'b0;
    set_nack = 1'b0;
    if (bus_stop) begin
      set_stop = engaged;
      st_n = ST_IDLE;
      matched_n = 1'b0;
      engaged_n = 1'b0;
    end else if (bus_start) begin
      set_stop = engaged;
      st_n = ST_RX;
      cnt_n = '0;
      second_n = 1'b0;
      engaged_n = 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh_n = rxb;
            if (cnt == LAST_BIT) begin
              st_n = ST_RXEND;
              if (!tx_en) begin
                dec_n = DEC_NONE;
              end else if (!second) begin
                if (rxb[7:3] == TEN_BIT_PREFIX && rxb[2:1] == own_addr[ADDR_W-1:ADDR_W-2]) begin
                  if (rxb[0]) dec_n = matched ? DEC_RD : DEC_NONE;
                  else        dec_n = DEC_W1;
                end else if (gc_en && rxb == '0) begin
                  dec_n = DEC_GC;
                end else begin
                  dec_n = DEC_NONE;
                end
                if (dec_n != DEC_RD) matched_n = 1'b0;
              end else begin
                if (rxb == own_addr[BYTE_W-1:0]) begin
                  dec_n = DEC_W2;
                  matched_n = 1'b1;
                end else begin
                  dec_n = DEC_NONE;
                  matched_n = 1'b0;
                end
              end
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_RXEND: begin
          if (scl_fall) begin
            if (dec != DEC_NONE) begin
              st_n = ST_ACK;
              engaged_n = 1'b1;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            unique case (dec)
              DEC_W1: begin
                st_n = ST_RX;
                cnt_n = '0;
                second_n = 1'b1;
              end
              DEC_RD:  st_n = ST_LOAD;
              default: st_n = ST_SKIP;
            endcase
          end
        end
        ST_LOAD: begin
          if (buf_full) begin
            take = 1'b1;
            sh_n = buf_data;
            cnt_n = '0;
            st_n = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_rise && cnt == '0) first_bit = 1'b1;
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              st_n = ST_MACK;
            end else begin
              cnt_n = cnt + 1'b1;
              sh_n = {sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_q) begin
              set_nack = 1'b1;
              st_n = ST_SKIP;
            end else begin
              st_n = ST_MWAIT;
            end
          end
        end
        ST_MWAIT: begin
          if (scl_fall) st_n = ST_LOAD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      dec <= DEC_NONE;
      cnt <= '0;
      sh <= '0;
      second <= 1'b0;
      matched <= 1'b0;
      engaged <= 1'b0;
    end else begin
      st <= st_n;
      dec <= dec_n;
      cnt <= cnt_n;
      sh <= sh_n;
      second <= second_n;
      matched <= matched_n;
      engaged <= engaged_n;
    end
  end

  assign sda_oe = (st == ST_ACK) | ((st == ST_TX) & ~sh[BYTE_W-1]);
  assign scl_oe = (st == ST_LOAD) & ~buf_full;
endmodule

// File: rtl/i2c10_slave_tx.sv
module i2c10_slave_tx
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flush,
  input  logic              rd_status,
  output logic              tde_flag,
  output logic              nack_flag,
  output logic              stop_flag,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic rst_int;
  logic scl_q, sda_q, scl_rise, scl_fall, bus_start, bus_stop;
  logic take, first_bit, set_stop, set_nack, buf_full;
  logic [BYTE_W-1:0] buf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  i2c10_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c10_txbuf u_buf (
    .clk(clk), .rst_n(rst_int), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush), .take(take), .first_bit(first_bit),
    .buf_data(buf_data), .buf_full(buf_full), .tde_flag(tde_flag)
  );

  i2c10_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_int), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .own_addr(own_addr), .gc_en(gc_en), .tx_en(tx_en),
    .buf_full(buf_full), .buf_data(buf_data), .take(take),
    .first_bit(first_bit), .set_stop(set_stop), .set_nack(set_nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2c10_status u_stat (
    .clk(clk), .rst_n(rst_int), .set_stop(set_stop), .set_nack(set_nack),
    .rd_status(rd_status), .tde_flag(tde_flag), .stop_flag(stop_flag),
    .nack_flag(nack_flag), .irq(irq)
  );
endmodule

// File: rtl/i2c10_slave_tx_chk.sv
module i2c10_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic sda_q,
  input logic scl_oe,
  input logic sda_oe,
  input logic wr_en,
  input logic tde_flag,
  input logic nack_flag
);
  // R3: the slave begins pulling SDA low only in the SCL low phase
  p_sda_pull_in_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  // R4: a CPU write always leaves the empty flag low
  p_write_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tde_flag);

  // R5: stretching only ever extends a low SCL phase
  p_stretch_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !scl_q);

  // R5: a write during a stretch frees SCL on the next cycle
  p_stretch_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && wr_en) |=> !scl_oe);

  // R6: a refused byte is seen only with SDA high on the bus
  p_nack_needs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_flag) |-> $past(sda_q));
endmodule

bind i2c10_slave_tx i2c10_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_en(wr_en),
  .tde_flag(tde_flag), .nack_flag(nack_flag)
);

// File: tb/sim_i2c10_slave_tx.sv
`timescale 1ns/1ps
module sim_i2c10_slave_tx;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mscl = 1'b1, msda = 1'b1;
  logic scl_oe, sda_oe, tde_flag, nack_flag, stop_flag, irq;
  logic [9:0] own_addr = 10'h000;
  logic gc_en = 1'b0, tx_en = 1'b1, wr_en = 1'b0, flush = 1'b0, rd_status = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic scl_bus, sda_bus;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign scl_bus = mscl & ~scl_oe;
  assign sda_bus = msda & ~sda_oe;

  i2c10_slave_tx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
    .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
    .rd_status(rd_status), .tde_flag(tde_flag), .nack_flag(nack_flag),
    .stop_flag(stop_flag), .irq(irq)
  );

  function automatic logic [7:0] head_byte(input logic [9:0] a, input logic rw);
    return {5'b11110, a[9:8], rw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask
  task automatic wait_high(); while (!scl_bus) @(negedge clk); endtask

  task automatic m_start();
    msda = 1'b1; qwait(); mscl = 1'b1; wait_high(); qwait();
    msda = 1'b0; qwait(); mscl = 1'b0; qwait();
  endtask

  task automatic m_stop();
    msda = 1'b0; qwait(); mscl = 1'b1; wait_high(); qwait();
    msda = 1'b1; qwait();
  endtask

  task automatic m_wbit(input logic b);
    msda = b; qwait(); mscl = 1'b1; wait_high(); qwait(); qwait();
    mscl = 1'b0; qwait();
  endtask

  task automatic m_rbit(output logic b);
    msda = 1'b1; qwait(); mscl = 1'b1; wait_high(); qwait();
    b = sda_bus; qwait(); mscl = 1'b0; qwait();
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    m_rbit(a);
    ack = ~a;
  endtask

  task automatic m_rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_rbit(v[i]);
  endtask

  task automatic cpu_wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cpu_rd();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // full ten-bit read; late=1 delays the CPU write of byte 1 past the master ACK
  task automatic read_txn(input logic [9:0] a, input int n, input bit late);
    logic [7:0] dat [0:3];
    logic [7:0] v;
    logic ack;
    for (int i = 0; i < 4; i++) dat[i] = 8'($urandom);
    @(negedge clk); own_addr = a;
    cpu_wr(dat[0]);
    m_start();
    m_wbyte(head_byte(a, 1'b0), ack); chk("R1 head ack", ack, 1);
    m_wbyte(a[7:0], ack);             chk("R1 low ack", ack, 1);
    m_start();
    chk("R8 flag on restart", stop_flag, 1);
    cpu_rd();
    m_wbyte(head_byte(a, 1'b1), ack); chk("R2 read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      m_rbyte(v);
      chk("R3 data byte", v, dat[i]);
      chk("R4 empty after first bit", tde_flag, 1);
      if (i < n - 1) begin
        if (late && i == 0) begin
          m_wbit(1'b0);
          repeat (20) @(negedge clk);
          chk("R5 stretch held", scl_oe, 1);
          chk("R5 scl low", scl_bus, 0);
          cpu_wr(dat[i+1]);
          chk("R5 stretch freed", scl_oe, 0);
        end else begin
          cpu_wr(dat[i+1]);
          chk("R4 cleared by write", tde_flag, 0);
          m_wbit(1'b0);
        end
      end else begin
        m_wbit(1'b1);
        chk("R6 nack flag", nack_flag, 1);
        chk("R6 sda released", sda_oe, 0);
        chk("R11 irq", irq, 1);
      end
    end
    m_stop();
    repeat (4) @(negedge clk);
    chk("R8 flag on stop", stop_flag, 1);
    cpu_rd();
    chk("R8 cleared by read", stop_flag, 0);
    chk("R8 nack cleared by read", nack_flag, 0);
  endtask

  task automatic run_all();
    logic ack;
    logic [7:0] v;
    logic [9:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 scl_oe", scl_oe, 0);
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 flags", {tde_flag, nack_flag, stop_flag}, 0);
    chk("R12 irq", irq, 0);

    // directed reads, then random ones
    read_txn(10'h2A5, 3, 1'b0);
    read_txn(10'h15A, 1, 1'b1);
    for (int t = 0; t < 8; t++) begin
      a = 10'($urandom);
      read_txn(a, 1 + int'($urandom % 4), bit'($urandom % 2));
    end

    // R2: read head without a prior write prefix
    @(negedge clk); own_addr = 10'h1C3;
    m_start();
    m_wbyte(head_byte(10'h1C3, 1'b1), ack); chk("R2 no prefix", ack, 0);
    m_stop();
    repeat (4) @(negedge clk);
    chk("R8 no flag without ack", stop_flag, 0);

    // R1: wrong low byte, then R2 read refused
    m_start();
    m_wbyte(head_byte(10'h1C3, 1'b0), ack); chk("R1 head ack", ack, 1);
    m_wbyte(8'hC4, ack);                    chk("R1 low mismatch", ack, 0);
    m_start();
    m_wbyte(head_byte(10'h1C3, 1'b1), ack); chk("R2 after mismatch", ack, 0);
    m_stop();
    cpu_rd();

    // R1: upper bits mismatch
    m_start();
    m_wbyte(head_byte(10'h2C3, 1'b0), ack); chk("R1 high mismatch", ack, 0);
    m_stop();

    // R9: general call
    gc_en = 1'b1;
    m_start();
    m_wbyte(8'h00, ack); chk("R9 gc on", ack, 1);
    m_stop();
    cpu_rd();
    gc_en = 1'b0;
    m_start();
    m_wbyte(8'h00, ack); chk("R9 gc off", ack, 0);
    m_stop();

    // R10: disabled
    tx_en = 1'b0;
    m_start();
    m_wbyte(head_byte(10'h1C3, 1'b0), ack); chk("R10 disabled", ack, 0);
    m_stop();
    tx_en = 1'b1;

    // R7: flush a preloaded byte, first data byte then stretches
    cpu_wr(8'h77);
    do_flush();
    m_start();
    m_wbyte(head_byte(10'h1C3, 1'b0), ack);
    m_wbyte(8'hC3, ack);
    m_start();
    m_wbyte(head_byte(10'h1C3, 1'b1), ack); chk("R2 read ack", ack, 1);
    repeat (30) @(negedge clk);
    chk("R7 stretch after flush", scl_oe, 1);
    cpu_wr(8'h3C);
    chk("R5 release after write", scl_oe, 0);
    m_rbyte(v);
    chk("R7 fresh byte sent", v, 8'h3C);
    m_wbit(1'b1);
    m_stop();
    cpu_rd();
  endtask

  initial begin
    void'($urandom(32'h5EED));
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule